// File: doc/BRIEF.md
# Hall Speed Pulse Selector

This block turns the three digitized Hall sensor bits of a three-phase brushless motor into one speed-feedback pulse. Two mode pins choose what the pulse follows. It can follow a single sensor, which gives one cycle per electrical revolution. It can instead follow a waveform built from all three sensors, which changes level on every commutation edge. Either choice can also pass through a divide-by-two stage.

The mode pins are modelled as "driven low" flags. A pin that is left open is never pulled low, so it reads as high. The block gives two forms of the same pulse. One is a logic-level copy. The other is an active-low pull-down enable for an open-drain pad: it is low while the pad should be pulled low, and high while the pad is released. Everything is synchronous to one clock with an active-high synchronous reset. The Hall bits are assumed to be already clean and digitized.

Top module: `hall_pulse_sel`

## Requirements
- R1: The mode is {n1, n2}, where a pin reads 0 only when its `*_low_i` flag is 1. n1=1 selects the three-sensor waveform and n1=0 selects sensor bit 0. n2=1 passes the selected waveform straight through and n2=0 halves it.
- R2: In mode n1=0, n2=1 the output equals Hall bit 0. Changes on bits 1 and 2 have no effect on the output.
- R3: In mode n1=1, n2=1 the output equals the XOR of the three Hall bits, so it changes level on every single-bit commutation step.
- R4: In mode n1=0, n2=0 the output toggles once for each 0-to-1 transition of Hall bit 0 and holds its level otherwise.
- R5: In mode n1=1, n2=0 the output toggles once for each 0-to-1 transition of the three-bit XOR and holds its level otherwise.
- R6: A mode pin whose low flag is 0 (open or undriven) reads as high, so both flags at 0 give the undivided three-sensor mode.
- R7: Any change of mode clears the divider. In a halved mode the output is therefore 0 right after the switch, and it stays 0 until the next 0-to-1 transition of the newly selected waveform.
- R8: Hall bits and mode pins sampled at one rising clock edge decide the output that appears after the second rising edge that follows.
- R9: While reset is asserted the output is 0, the divider is cleared and the internal mode is the undivided three-sensor mode.
- R10: The open-drain enable `hp_od_n_o` is low exactly when `hp_level_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_i | input | HALL_W (3) | Digitized Hall sensor bits |
| n1_low_i | input | 1 | 1 when mode pin n1 is driven low; 0 reads as high |
| n2_low_i | input | 1 | 1 when mode pin n2 is driven low; 0 reads as high |
| hp_level_o | output | 1 | Logic-level speed pulse |
| hp_od_n_o | output | 1 | Active-low pull-down enable for an open-drain pad |

## Verification
The hardest case is a mode switch into a halved mode at a moment when the newly selected waveform is already high. A careless divider would count that level as a rising edge and emit a runt pulse. The stimulus therefore switches modes in the middle of commutation sequences, with Hall patterns chosen so that the new source is at 1 on the switch cycle. It also switches back and forth between the two halved modes, so that the divider is cleared while it holds a 1. A pseudo-random phase then mixes Hall steps with occasional mode changes, and a reference model counts rising edges independently of the design.

// File: rtl/hps_pkg.sv
package hps_pkg;

    // Mode code is {n1, n2}: n1 picks the source, n2 bypasses the halver.
    typedef enum logic [1:0] {
        HP_ONE_HALF = 2'b00,
        HP_ONE      = 2'b01,
        HP_ALL_HALF = 2'b10,
        HP_ALL      = 2'b11
    } hp_mode_e;

    localparam hp_mode_e HP_RESET_MODE = HP_ALL;

    // An open pin is never flagged as driven low, so it reads as high.
    function automatic hp_mode_e pins_to_mode(input logic n1_low, input logic n2_low);
        logic [1:0] code;
        code = {~n1_low, ~n2_low};
        return hp_mode_e'(code);
    endfunction

    function automatic logic mode_uses_all(input hp_mode_e m);
        return (m == HP_ALL) || (m == HP_ALL_HALF);
    endfunction

    function automatic logic mode_halves(input hp_mode_e m);
        return (m == HP_ONE_HALF) || (m == HP_ALL_HALF);
    endfunction

endpackage

// File: rtl/hps_capture.sv
module hps_capture
    import hps_pkg::*;
#(
    parameter int HALL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALL_W-1:0] hall_i,
    input  logic              n1_low_i,
    input  logic              n2_low_i,
    output logic [HALL_W-1:0] hall_q_o,
    output hp_mode_e          mode_q_o,
    output hp_mode_e          mode_d_o,
    output logic              mode_chg_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hall_q_o <= '0;
            mode_q_o <= HP_RESET_MODE;
            mode_d_o <= HP_RESET_MODE;
        end else begin
            hall_q_o <= hall_i;
            mode_q_o <= pins_to_mode(n1_low_i, n2_low_i);
            mode_d_o <= mode_q_o;
        end
    end

    assign mode_chg_o = (mode_q_o != mode_d_o);

endmodule

// File: rtl/hps_wave_sel.sv
module hps_wave_sel #(
    parameter int HALL_W     = 3,
    parameter int SINGLE_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALL_W-1:0] hall_q_i,
    input  logic              use_all_i,
    output logic              wave_o,
    output logic              wave_d_o,
    output logic              rise_o
);

    logic all_wave;

    generate
        if (HALL_W > 1) begin : g_multi
            assign all_wave = ^hall_q_i;
        end else begin : g_single
            assign all_wave = hall_q_i[0];
        end
    endgenerate

    assign wave_o = use_all_i ? all_wave : hall_q_i[SINGLE_IDX];

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_d_o <= 1'b0;
        end else begin
            wave_d_o <= wave_o;
        end
    end

    assign rise_o = wave_o & ~wave_d_o;

endmodule

// File: rtl/hps_toggle_div.sv
module hps_toggle_div (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic rise_i,
    output logic q_o
);

    // Clearing wins over a rising edge seen in the same cycle.
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            q_o <= 1'b0;
        end else if (rise_i) begin
            q_o <= ~q_o;
        end
    end

endmodule

// File: rtl/hall_pulse_sel.sv
module hall_pulse_sel
    import hps_pkg::*;
#(
    parameter int HALL_W     = 3,
    parameter int SINGLE_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALL_W-1:0] hall_i,
    input  logic              n1_low_i,
    input  logic              n2_low_i,
    output logic              hp_level_o,
    output logic              hp_od_n_o
);

    logic [HALL_W-1:0] hall_q;
    hp_mode_e          mode_q;
    hp_mode_e          mode_d;
    logic              mode_chg;
    logic              wave_now;
    logic              wave_d;
    logic              wave_rise;
    logic              half_q;

    hps_capture #(.HALL_W(HALL_W)) cap_i (
        .clk        (clk),
        .rst        (rst),
        .hall_i     (hall_i),
        .n1_low_i   (n1_low_i),
        .n2_low_i   (n2_low_i),
        .hall_q_o   (hall_q),
        .mode_q_o   (mode_q),
        .mode_d_o   (mode_d),
        .mode_chg_o (mode_chg)
    );

    hps_wave_sel #(.HALL_W(HALL_W), .SINGLE_IDX(SINGLE_IDX)) wsel_i (
        .clk       (clk),
        .rst       (rst),
        .hall_q_i  (hall_q),
        .use_all_i (mode_uses_all(mode_q)),
        .wave_o    (wave_now),
        .wave_d_o  (wave_d),
        .rise_o    (wave_rise)
    );

    hps_toggle_div div_i (
        .clk     (clk),
        .rst     (rst),
        .clear_i (mode_chg),
        .rise_i  (wave_rise),
        .q_o     (half_q)
    );

    // wave_d and half_q were both formed under mode_d.
    assign hp_level_o = mode_halves(mode_d) ? half_q : wave_d;
    assign hp_od_n_o  = hp_level_o;

endmodule

// File: rtl/hall_pulse_sel_chk.sv
module hall_pulse_sel_chk #(
    parameter int HALL_W     = 3,
    parameter int SINGLE_IDX = 0
) (
    input logic              clk,
    input logic              rst,
    input logic [HALL_W-1:0] hall_i,
    input logic              n1_low_i,
    input logic              n2_low_i,
    input logic              hp_level_o
);

    logic [2:0] run_cnt;
    logic       w_one;
    logic       w_all;
    logic       live;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (run_cnt != 3'd7) begin
            run_cnt <= run_cnt + 3'd1;
        end
    end

    assign w_one = hall_i[SINGLE_IDX];
    assign w_all = ^hall_i;
    assign live  = (run_cnt >= 3'd4);

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> !hp_level_o); // R9

    AST_ONE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (live && $past(n1_low_i, 2) && !$past(n2_low_i, 2))
        |-> (hp_level_o == $past(w_one, 2))); // R2

    AST_ALL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(n1_low_i, 2) && !$past(n2_low_i, 2))
        |-> (hp_level_o == $past(w_all, 2))); // R3

    AST_SWITCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (live && $past(n2_low_i, 2) &&
         (($past(n1_low_i, 2) != $past(n1_low_i, 3)) ||
          ($past(n2_low_i, 2) != $past(n2_low_i, 3))))
        |-> !hp_level_o); // R7

    AST_HALF_STEP: assert property (@(posedge clk) disable iff (rst)
        (live && $past(n2_low_i, 2) && $past(n2_low_i, 3) &&
         ($past(n1_low_i, 2) == $past(n1_low_i, 3)))
        |-> (hp_level_o == ($past(hp_level_o) ^
             ($past(n1_low_i, 2) ? ($past(w_one, 2) & ~$past(w_one, 3))
                                 : ($past(w_all, 2) & ~$past(w_all, 3)))))); // R4 R5

endmodule

bind hall_pulse_sel hall_pulse_sel_chk #(.HALL_W(HALL_W), .SINGLE_IDX(SINGLE_IDX)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .hall_i     (hall_i),
    .n1_low_i   (n1_low_i),
    .n2_low_i   (n2_low_i),
    .hp_level_o (hp_level_o)
);

// File: tb/hall_pulse_sel_tb_top.sv
module hall_pulse_sel_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall = 3'b000;
    logic       n1_low = 1'b0;
    logic       n2_low = 1'b0;
    logic       level;
    logic       od_n;

    always #2 clk = ~clk;

    hall_pulse_sel dut_i (
        .clk        (clk),
        .rst        (rst),
        .hall_i     (hall),
        .n1_low_i   (n1_low),
        .n2_low_i   (n2_low),
        .hp_level_o (level),
        .hp_od_n_o  (od_n)
    );

    typedef struct {
        int    due;
        logic  exp;
        string tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    running = 0;
    bit    finished = 0;

    // Reference model state, reset values per R9.
    logic [1:0] m_mode = 2'b11;
    logic       m_wave = 1'b0;
    logic       m_div  = 1'b0;

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Driver: one input vector per cycle, expected output queued (R8: 2 edges later).
    task automatic step(input logic [2:0] h, input logic n1l, input logic n2l);
        logic [1:0] mode;
        logic       wave;
        item_t      it;
        string      tag;
        @(negedge clk);
        hall = h; n1_low = n1l; n2_low = n2l;
        mode = {~n1l, ~n2l};                       // R1, R6
        wave = mode[1] ? ^h : h[0];
        tag  = (mode == 2'b11) ? "R3" : (mode == 2'b01) ? "R2" :
               (mode == 2'b00) ? "R4" : "R5";
        if (mode != m_mode) begin
            m_div = 1'b0;
            tag = {tag, " R7"};
        end else if (wave && !m_wave) begin
            m_div = ~m_div;
        end
        if (!n1l || !n2l) tag = {tag, " R6"};
        tag = {tag, " R1 R8"};
        m_mode = mode;
        m_wave = wave;
        it.due = cyc + 2;
        it.exp = mode[0] ? wave : m_div;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: pops expected items when due and compares after the edge.
    always @(posedge clk) begin
        cyc++;
        #1;
        if (running) begin
            while (q.size() > 0 && q[0].due == cyc) begin
                item_t it;
                it = q.pop_front();
                check(level, it.exp, it.tag);
                check(od_n, level, "R10");
            end
        end
    end

    task automatic sequence6(input logic n1l, input logic n2l, input int reps);
        logic [2:0] seq [6];
        seq = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
        for (int r = 0; r < reps; r++)
            for (int i = 0; i < 6; i++) step(seq[i], n1l, n2l);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        check(level, 1'b0, "R9 reset level");
        check(od_n, 1'b0, "R9 reset enable");
        hall = 3'b111; n1_low = 1'b1; n2_low = 1'b1;
        repeat (2) @(negedge clk);
        check(level, 1'b0, "R9 reset holds with inputs active");
        hall = 3'b000; n1_low = 1'b0; n2_low = 1'b0;
        rst = 1'b0;
        running = 1;

        // R3 with both pins open (R6)
        sequence6(1'b0, 1'b0, 2);
        // R2: single sensor, bits 1 and 2 moving alone must not matter
        sequence6(1'b1, 1'b0, 2);
        step(3'b001, 1'b1, 1'b0); step(3'b011, 1'b1, 1'b0);
        step(3'b111, 1'b1, 1'b0); step(3'b101, 1'b1, 1'b0);
        step(3'b000, 1'b1, 1'b0); step(3'b110, 1'b1, 1'b0);
        // R4: single sensor halved, entered while bit 0 is high (R7 runt case)
        step(3'b101, 1'b1, 1'b1);
        sequence6(1'b1, 1'b1, 3);
        // R5: all sensors halved, entered while XOR is high
        step(3'b100, 1'b0, 1'b1);
        sequence6(1'b0, 1'b1, 3);
        // R7: toggle between halved modes while the divider holds 1
        step(3'b001, 1'b0, 1'b1); step(3'b001, 1'b1, 1'b1);
        step(3'b011, 1'b1, 1'b1); step(3'b001, 1'b1, 1'b1);
        step(3'b111, 1'b0, 1'b1); step(3'b111, 1'b0, 1'b1);
        step(3'b110, 1'b0, 1'b1); step(3'b010, 1'b1, 1'b1);
        // Mixed random phase
        lfsr = 8'hA5;
        for (int i = 0; i < 400; i++) begin
            logic n1l, n2l;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            n1l = ((i / 37) % 2) == 1;
            n2l = ((i / 53) % 2) == 0;
            step(lfsr[2:0], n1l, n2l);
        end
        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R8: actual %0d pending expected 0 pending", q.size());
        end
        finish_run();
    end

endmodule